// File: doc/BRIEF.md
# Direct Torque Control Switch Selector with Per-Phase Lockout

This block picks the three inverter leg commands for a two-level direct torque control loop. A new sample is accepted once per control period. For each sample, two hysteresis comparators turn the torque error and the flux error into one "raise" or "lower" bit each. Those two bits and the flux sector number address a switching table, which gives a candidate voltage vector.

The candidate vector is not applied blindly. Each phase leg has its own lockout timer. A leg whose candidate differs from the value it holds now switches only if its timer has run out. After a switch, the timer holds that leg for a fixed number of accepted samples. A change that is refused is not remembered. It is simply evaluated again from the next sample's table output.

Samples arrive on a valid/ready stream. `in_ready` is held high, so the block never applies back-pressure and every cycle with `in_valid` high is one accepted sample. Cycles with `in_valid` low change nothing, not even the timers. The switch outputs are registered, and `out_valid` pulses in the cycle after each accepted sample to mark fresh outputs.

Top module: `dtc_switch_ctrl`

## Requirements
- R1: After reset, `sw_a`, `sw_b`, `sw_c` and `out_valid` are 0, both comparator states are 0, and every phase is authorized, so the first accepted change on any phase is applied at once.
- R2: The torque comparator state becomes 1 on an accepted sample with `trq_est < trq_ref - trq_band`, and becomes 0 when `trq_est > trq_ref + trq_band`. Otherwise it keeps its value, including at exactly ref ± band. All values are signed 16-bit.
- R3: The flux comparator follows the same rule on `flx_est`, `flx_ref` and `flx_band`.
- R4: Vectors V1..V6 are encoded as (a,b,c) = 100, 110, 010, 011, 001, 101. For sector n (1..6) the candidate is chosen as follows, with indices taken modulo 6:
  - flux 1 and torque 1: V(n+1)
  - flux 1 and torque 0: V(n-1)
  - flux 0 and torque 1: V(n+2)
  - flux 0 and torque 0: V(n-2)
- R5: A sector value of 0 or 7 gives a candidate equal to the applied state, so no phase switches. The timers still count that sample.
- R6: A phase switches only when its lockout count is zero. A switch loads the count with LOCK_SAMPLES-1. Each accepted sample with a nonzero count decrements it. As a result, two switches of one phase are at least LOCK_SAMPLES accepted samples apart, and exactly that spacing is allowed.
- R7: A change refused by the lockout is not stored. At each later sample, the phase follows that sample's candidate once it is authorized.
- R8: Each phase has its own timer. A locked phase does not stop another phase from switching in the same sample.
- R9: `in_ready` is always 1. `out_valid` is 1 exactly in the cycle after an accepted sample. The switch outputs change only at that edge.
- R10: Cycles without an accepted sample leave the outputs, the comparator states and the timers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe (stream valid) |
| in_ready | output | 1 | Stream ready, always 1 |
| sector | input | 3 | Flux sector, 1..6 are valid |
| trq_est | input | 16 | Estimated torque, signed |
| trq_ref | input | 16 | Torque reference, signed |
| trq_band | input | 16 | Torque half band, signed, not negative |
| flx_est | input | 16 | Estimated flux, signed |
| flx_ref | input | 16 | Flux reference, signed |
| flx_band | input | 16 | Flux half band, signed, not negative |
| out_valid | output | 1 | Pulses in the cycle after an accepted sample |
| sw_a | output | 1 | Phase A leg command |
| sw_b | output | 1 | Phase B leg command |
| sw_c | output | 1 | Phase C leg command |

## Verification
The bench targets the following corner cases and the fault each one would expose:
- **Lockout boundary.** A change arrives exactly LOCK_SAMPLES samples after a switch. An off-by-one timer would apply it one sample late, or one sample too early.
- **Hysteresis band edges.** The estimate sits exactly on ref ± band. A comparator with a strict/non-strict mix-up would toggle there instead of holding.
- **Idle gaps inside a lockout.** `in_valid` drops for several cycles while a timer is running. A timer that counts clock cycles instead of samples would release the phase early.
- **Invalid sectors, and one locked phase beside free ones.** The first would expose a wrongly indexed table. The second would expose a shared timer, which would freeze every leg whenever one leg is locked.

// File: rtl/dtc_sw_pkg.sv
package dtc_sw_pkg;
  localparam int unsigned NUM_PHASES = 3;
  localparam int unsigned NUM_SECTORS = 6;

  typedef logic [NUM_PHASES-1:0] sw_vec_t;  // bit 2 = a, bit 1 = b, bit 0 = c

  // Active vector for zero-based index 0..5 (V1..V6)
  function automatic sw_vec_t active_vec(input logic [3:0] idx);
    case (idx)
      4'd0:    active_vec = 3'b100;
      4'd1:    active_vec = 3'b110;
      4'd2:    active_vec = 3'b010;
      4'd3:    active_vec = 3'b011;
      4'd4:    active_vec = 3'b001;
      default: active_vec = 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/dtc_hyst_cmp.sv
module dtc_hyst_cmp #(
  parameter int unsigned W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic signed [W-1:0] est,
  input  logic signed [W-1:0] ref_val,
  input  logic signed [W-1:0] band,
  output logic                state_d,
  output logic                state_q
);
  localparam int unsigned WX = W + 1;

  logic signed [WX-1:0] lo_lim, hi_lim, est_x;

  always_comb begin
    est_x  = WX'(est);
    lo_lim = WX'(ref_val) - WX'(band);
    hi_lim = WX'(ref_val) + WX'(band);
    if (est_x < lo_lim)      state_d = 1'b1;
    else if (est_x > hi_lim) state_d = 1'b0;
    else                     state_d = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= 1'b0;
    else if (strobe) state_q <= state_d;
  end

  // One comparator module serves torque (R2) and flux (R3)
  p_below_sets_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (WX'(est) < WX'(ref_val) - WX'(band))) |=> state_q);
  p_above_clears_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (WX'(est) > WX'(ref_val) + WX'(band))) |=> !state_q);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(state_q));
endmodule

// File: rtl/dtc_sw_table.sv
module dtc_sw_table
  import dtc_sw_pkg::*;
(
  input  logic [2:0] sector,
  input  logic       flx_up,
  input  logic       trq_up,
  input  sw_vec_t    applied,
  output sw_vec_t    cand
);
  logic [3:0] step, sum, idx;

  always_comb begin
    case ({flx_up, trq_up})
      2'b11:   step = 4'd1;  // +1
      2'b10:   step = 4'd5;  // -1
      2'b01:   step = 4'd2;  // +2
      default: step = 4'd4;  // -2
    endcase
    sum = {1'b0, sector} - 4'd1 + step;
    idx = (sum >= 4'(NUM_SECTORS)) ? sum - 4'(NUM_SECTORS) : sum;
    if (sector == 3'd0 || sector == 3'd7) cand = applied;
    else                                  cand = active_vec(idx);
  end
endmodule

// File: rtl/dtc_phase_lock.sv
module dtc_phase_lock #(
  parameter int unsigned LOCK_SAMPLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic cand,
  output logic sw_q
);
  localparam int unsigned CW = $clog2(LOCK_SAMPLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LOCK_SAMPLES - 1);

  logic [CW-1:0] cnt_q;
  logic          free;

  assign free = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      cnt_q <= '0;
    end else if (strobe) begin
      if (free && (cand != sw_q)) begin
        sw_q  <= cand;
        cnt_q <= RELOAD;
      end else if (!free) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  p_locked_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !free) |=> $stable(sw_q));
  p_switch_reloads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_q) |-> (cnt_q == RELOAD));
  p_free_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && free) |=> (sw_q == $past(cand)));
  p_idle_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(sw_q) && $stable(cnt_q)));
endmodule

// File: rtl/dtc_switch_ctrl.sv
module dtc_switch_ctrl
  import dtc_sw_pkg::*;
#(
  parameter int unsigned W            = 16,
  parameter int unsigned LOCK_SAMPLES = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          sector,
  input  logic signed [W-1:0] trq_est,
  input  logic signed [W-1:0] trq_ref,
  input  logic signed [W-1:0] trq_band,
  input  logic signed [W-1:0] flx_est,
  input  logic signed [W-1:0] flx_ref,
  input  logic signed [W-1:0] flx_band,
  output logic                out_valid,
  output logic                sw_a,
  output logic                sw_b,
  output logic                sw_c
);
  logic    take;
  logic    trq_d, trq_q, flx_d, flx_q;
  sw_vec_t applied, cand;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  dtc_hyst_cmp #(.W(W)) u_trq_cmp (
    .clk(clk), .rst_n(rst_n), .strobe(take), .est(trq_est), .ref_val(trq_ref),
    .band(trq_band), .state_d(trq_d), .state_q(trq_q));

  dtc_hyst_cmp #(.W(W)) u_flx_cmp (
    .clk(clk), .rst_n(rst_n), .strobe(take), .est(flx_est), .ref_val(flx_ref),
    .band(flx_band), .state_d(flx_d), .state_q(flx_q));

  dtc_sw_table u_table (
    .sector(sector), .flx_up(flx_d), .trq_up(trq_d), .applied(applied), .cand(cand));

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    dtc_phase_lock #(.LOCK_SAMPLES(LOCK_SAMPLES)) u_lock (
      .clk(clk), .rst_n(rst_n), .strobe(take), .cand(cand[p]), .sw_q(applied[p]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= take;
  end

  assign sw_a = applied[2];
  assign sw_b = applied[1];
  assign sw_c = applied[0];

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_bad_sector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (sector == 3'd0 || sector == 3'd7)) |=> $stable({sw_a, sw_b, sw_c}));
endmodule

// File: tb/dtc_switch_ctrl_tb.sv
`timescale 1ns/1ps
module dtc_switch_ctrl_tb_top;
  localparam int LOCK = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] sector = 3'd0;
  logic signed [15:0] trq_est = 0, trq_ref = 0, trq_band = 0;
  logic signed [15:0] flx_est = 0, flx_ref = 0, flx_band = 0;
  logic out_valid, sw_a, sw_b, sw_c;

  int errors = 0;
  int checks = 0;

  // reference model state
  int m_trq = 0, m_flx = 0;
  int m_sw[3] = '{0, 0, 0};
  int m_cnt[3] = '{0, 0, 0};
  int m_ov = 0;

  always #4 clk = ~clk;

  dtc_switch_ctrl #(.W(16), .LOCK_SAMPLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sector(sector), .trq_est(trq_est), .trq_ref(trq_ref), .trq_band(trq_band),
    .flx_est(flx_est), .flx_ref(flx_ref), .flx_band(flx_band),
    .out_valid(out_valid), .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c));

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // V1..V6 as (a,b,c), index 0..5 (R4)
  function automatic int vec_of(int i);
    case (i)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic int cmp_next(int st, int est, int rf, int bd);
    if (est < rf - bd) return 1;
    if (est > rf + bd) return 0;
    return st;
  endfunction

  task automatic model_step(bit v, int sec, int te, int tr, int tb, int fe, int fr, int fb);
    int cand, cur, off, bitp;
    m_ov = v;
    if (!v) return;
    m_trq = cmp_next(m_trq, te, tr, tb);
    m_flx = cmp_next(m_flx, fe, fr, fb);
    cur = m_sw[0] * 4 + m_sw[1] * 2 + m_sw[2];
    if (sec < 1 || sec > 6) begin
      cand = cur;
    end else begin
      if (m_flx == 1 && m_trq == 1) off = 1;
      else if (m_flx == 1) off = -1;
      else if (m_trq == 1) off = 2;
      else off = -2;
      cand = vec_of(((sec - 1) + off + 6) % 6);
    end
    for (int p = 0; p < 3; p++) begin
      bitp = (cand >> (2 - p)) & 1;
      if (m_cnt[p] == 0 && bitp != m_sw[p]) begin
        m_sw[p] = bitp;
        m_cnt[p] = LOCK - 1;
      end else if (m_cnt[p] > 0) begin
        m_cnt[p]--;
      end
    end
  endtask

  task automatic compare(string req);
    chk({req, " sw_a"}, sw_a, m_sw[0]);
    chk({req, " sw_b"}, sw_b, m_sw[1]);
    chk({req, " sw_c"}, sw_c, m_sw[2]);
    chk({req, " out_valid R9"}, out_valid, m_ov);
    chk("R9 in_ready", in_ready, 1);
  endtask

  task automatic step(string req, bit v, int sec, int te, int tr, int tb, int fe, int fr, int fb);
    @(negedge clk);
    in_valid = v; sector = 3'(sec);
    trq_est = 16'(te); trq_ref = 16'(tr); trq_band = 16'(tb);
    flx_est = 16'(fe); flx_ref = 16'(fr); flx_band = 16'(fb);
    model_step(v, sec, te, tr, tb, fe, fr, fb);
    @(posedge clk);
    #1;
    compare(req);
  endtask

  // shorthand: torque up/down and flux up/down via estimates far outside band
  task automatic drive(string req, int sec, bit tup, bit fup);
    step(req, 1'b1, sec, tup ? 0 : 2000, 1000, 250, fup ? 0 : 2000, 1000, 100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    compare("R1 after release");

    // R1/R4: first change applied at once; sector 1, flux up, torque up -> V2
    drive("R1 R4 first switch", 1, 1'b1, 1'b1);
    // R8: a,b locked; c free; sector 3 up/up -> V4 011
    drive("R8 independent phases", 3, 1'b1, 1'b1);
    // R10: idle gap does not count down
    for (int i = 0; i < 20; i++) step("R10 idle", 1'b0, 5, 0, 0, 0, 0, 0, 0);
    // R7: keep requesting a change while locked; R6 boundary at LOCK samples
    for (int i = 0; i < LOCK + 2; i++) drive("R6 R7 lockout window", 5, 1'b0, 1'b0);
    // R2/R3 band edges: hold at exactly ref +/- band
    step("R2 hold at upper edge", 1'b1, 2, 1250, 1000, 250, 1100, 1000, 100);
    step("R2 below band", 1'b1, 2, 749, 1000, 250, 1100, 1000, 100);
    step("R2 hold at lower edge", 1'b1, 2, 750, 1000, 250, 900, 1000, 100);
    step("R3 below band", 1'b1, 2, 1000, 1000, 250, 899, 1000, 100);
    step("R3 above band", 1'b1, 2, 1000, 1000, 250, 1101, 1000, 100);
    step("R2 above band", 1'b1, 2, 1251, 1000, 250, 1000, 1000, 100);
    // R4 sweep of all sectors and comparator combinations, spaced past lockout
    for (int s = 1; s <= 6; s++)
      for (int c = 0; c < 4; c++) begin
        drive("R4 table sweep", s, c[0], c[1]);
        for (int k = 0; k < LOCK; k++) drive("R4 R5 settle", 0, c[0], c[1]);
      end
    // R5: invalid sectors
    for (int i = 0; i < 10; i++) drive("R5 sector 7", 7, i[0], i[1]);
    // random stream with gaps
    for (int i = 0; i < 4000; i++) begin
      int sec, te, fe;
      bit v;
      v = ($urandom % 4) != 0;
      sec = $urandom % 8;
      te = 1000 + int'($urandom % 1201) - 600;
      fe = 800 + int'($urandom % 401) - 200;
      step("R2 R3 R4 R6 R7 R8 random", v, sec, te, 1000, 250, fe, 800, 100);
    end
    finish_run();
  end
endmodule